// File: doc/BRIEF.md
# Heat-Cell to 4bpp Framebuffer Packer

This block turns a two-dimensional buffer of heat cells into 4-bit-per-pixel video memory words. Software or a sequencer supplies a start pulse together with a screen origin. The block then walks the cell buffer in raster order. It reduces each 7-bit cell to a 4-bit palette index and gathers eight indices into one 32-bit word. Each word goes out on a framebuffer write port that has a valid/ready handshake.

Each row of cells covers a fixed run of consecutive words in video memory. Within a row the write address advances by one word per accepted write. At every new row the address is loaded again from a row base, and that base moves down by one screen line. The caller owns the cell buffer, which is read through a plain address/data port with combinational data return. Palette lookup and video timing belong to other blocks.

Top module: `heat_fb_packer`

## Requirements
- R1: After reset, and until a start pulse arrives, `busy`, `done`, `wr_valid` and `cell_rd_en` are all 0.
- R2: The pixel index of a cell is the cell value shifted right logically by 3. For a 7-bit cell this is bits 6:3.
- R3: Each word holds eight pixels from consecutive cells. The first cell read goes to bits 31:28, the second to bits 27:24, and so on down to the eighth in bits 3:0.
- R4: The first word of a frame is written to address `org_y*80 + (org_x >> 3)`. The three low bits of `org_x` have no effect.
- R5: Within a row, each accepted word is followed by a word at the next higher address.
- R6: The first word of each row after the first goes to the first address of the previous row plus 80.
- R7: A frame writes 80 rows of 40 words, 3200 words in all. It reads cell addresses 0 to 25599 exactly once each, in increasing order. Word k of the frame holds cells 8k to 8k+7.
- R8: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr` and `wr_data` hold their values, and `cell_rd_en` stays 0.
- R9: `done` is 1 for exactly one cycle, the cycle right after the last word of the last row is accepted. In that cycle `busy` is already 0.
- R10: A start pulse that arrives while `busy` is 1 has no effect. The running frame keeps its origin, read order and word count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame; taken only when idle |
| org_x | input | 10 | Screen x origin in pixels |
| org_y | input | 9 | Screen y origin in lines |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse after the final word is accepted |
| cell_rd_en | output | 1 | Cell read strobe |
| cell_rd_addr | output | 15 | Linear cell index, row-major |
| cell_rd_data | input | 7 | Cell value for `cell_rd_addr`, same cycle |
| wr_valid | output | 1 | A video word is offered |
| wr_ready | input | 1 | The framebuffer takes the word at this edge |
| wr_addr | output | 16 | Video word address |
| wr_data | output | 32 | Eight packed pixel indices |

## Verification
The hardest situation to reach is a long backpressure stall on the last word of a row. At that point the row reload, the stall hold and the row-base step all act together, and it only happens once every forty words. The bench runs three whole frames with different origins and cell seeds. It holds `wr_ready` high in one frame and drives it randomly in the other two, at 70 % and 35 %, so that stalls fall on row ends many times. It also places a start pulse mid-frame with a different origin to confirm that pulse is ignored.

// File: rtl/hcp_pkg.sv
package hcp_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FILL = 2'd1,
      ST_SEND = 2'd2
   } hcp_state_e;
endpackage

// File: rtl/hcp_pack.sv
module hcp_pack #(
   parameter int CELL_W = 7,
   parameter int PIX_W  = 4,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic [CELL_W-1:0] cell_data,
   output logic [WORD_W-1:0] word
);
   localparam int SHIFT = CELL_W - PIX_W;

   logic [PIX_W-1:0] pix;

   generate
      if (SHIFT == 0) begin : g_direct
         assign pix = cell_data;
      end else begin : g_scaled
         logic [CELL_W-1:0] scaled;
         assign scaled = cell_data >> SHIFT;
         assign pix    = scaled[PIX_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word <= '0;
      end else if (shift_en) begin
         word <= {word[WORD_W-PIX_W-1:0], pix};
      end
   end

   // R2: newest nibble equals the top bits of the cell just read
   assert_pixel_scale_R2: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> word[PIX_W-1:0] == $past(cell_data[CELL_W-1 -: PIX_W]));

   // R3: older nibbles move one position towards the MSB
   assert_nibble_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> word[WORD_W-1:PIX_W] == $past(word[WORD_W-PIX_W-1:0]));
endmodule

// File: rtl/hcp_addr.sv
module hcp_addr #(
   parameter int FB_ADDR_W  = 16,
   parameter int X_W        = 10,
   parameter int Y_W        = 9,
   parameter int LINE_WORDS = 80,
   parameter int ROW_WORDS  = 40,
   parameter int XSH        = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load_frame,
   input  logic [X_W-1:0]       org_x,
   input  logic [Y_W-1:0]       org_y,
   input  logic                 next_word,
   input  logic                 next_row,
   output logic [FB_ADDR_W-1:0] wr_addr
);
   localparam logic [FB_ADDR_W-1:0] LINE_STEP = FB_ADDR_W'(LINE_WORDS);

   logic [FB_ADDR_W-1:0] row_base;
   logic [FB_ADDR_W-1:0] addr_q;
   logic [FB_ADDR_W-1:0] start_addr;
   logic [X_W-1:0]       word_x;

   assign word_x     = org_x >> XSH;
   assign start_addr = FB_ADDR_W'(org_y) * LINE_STEP + FB_ADDR_W'(word_x);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_base <= '0;
         addr_q   <= '0;
      end else if (load_frame) begin
         row_base <= start_addr;
         addr_q   <= start_addr;
      end else if (next_row) begin
         row_base <= row_base + LINE_STEP;
         addr_q   <= row_base + LINE_STEP;
      end else if (next_word) begin
         addr_q   <= addr_q + 1'b1;
      end
   end

   assign wr_addr = addr_q;

   // R5: consecutive words within a row
   assert_word_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      next_word |=> addr_q == $past(addr_q) + 1'b1);

   // R6: the step from the last word of a row to the first of the next
   assert_row_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      next_row |=> addr_q == $past(addr_q) + FB_ADDR_W'(LINE_WORDS - ROW_WORDS + 1));
endmodule

// File: rtl/hcp_seq.sv
module hcp_seq
   import hcp_pkg::*;
#(
   parameter int PIX_PER_WORD = 8,
   parameter int ROW_WORDS    = 40,
   parameter int ROWS         = 80,
   parameter int CELL_ADDR_W  = 15
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic                   wr_ready,
   output logic                   busy,
   output logic                   done,
   output logic                   fill,
   output logic                   wr_valid,
   output logic                   load_frame,
   output logic                   next_word,
   output logic                   next_row,
   output logic [CELL_ADDR_W-1:0] cell_idx
);
   localparam int NIB_W  = (PIX_PER_WORD > 1) ? $clog2(PIX_PER_WORD) : 1;
   localparam int WCNT_W = (ROW_WORDS > 1) ? $clog2(ROW_WORDS) : 1;
   localparam int RCNT_W = (ROWS > 1) ? $clog2(ROWS) : 1;
   localparam logic [NIB_W-1:0]  NIB_LAST  = NIB_W'(PIX_PER_WORD - 1);
   localparam logic [WCNT_W-1:0] WORD_LAST = WCNT_W'(ROW_WORDS - 1);
   localparam logic [RCNT_W-1:0] ROW_LAST  = RCNT_W'(ROWS - 1);

   hcp_state_e        state;
   logic [NIB_W-1:0]  nib_cnt;
   logic [WCNT_W-1:0] word_cnt;
   logic [RCNT_W-1:0] row_cnt;
   logic              done_q;
   logic              accept;
   logic              row_end;
   logic              frame_end;

   assign accept     = (state == ST_SEND) && wr_ready;
   assign row_end    = (word_cnt == WORD_LAST);
   assign frame_end  = row_end && (row_cnt == ROW_LAST);
   assign load_frame = (state == ST_IDLE) && start;
   assign next_word  = accept && !row_end;
   assign next_row   = accept && row_end && !frame_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         nib_cnt  <= '0;
         word_cnt <= '0;
         row_cnt  <= '0;
         cell_idx <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state    <= ST_FILL;
                  nib_cnt  <= '0;
                  word_cnt <= '0;
                  row_cnt  <= '0;
                  cell_idx <= '0;
               end
            end
            ST_FILL: begin
               cell_idx <= cell_idx + 1'b1;
               if (nib_cnt == NIB_LAST) begin
                  nib_cnt <= '0;
                  state   <= ST_SEND;
               end else begin
                  nib_cnt <= nib_cnt + 1'b1;
               end
            end
            ST_SEND: begin
               if (wr_ready) begin
                  if (row_end) begin
                     word_cnt <= '0;
                     if (frame_end) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                     end else begin
                        row_cnt <= row_cnt + 1'b1;
                        state   <= ST_FILL;
                     end
                  end else begin
                     word_cnt <= word_cnt + 1'b1;
                     state    <= ST_FILL;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state != ST_IDLE);
   assign fill     = (state == ST_FILL);
   assign wr_valid = (state == ST_SEND);
   assign done     = done_q;

   // R1: an idle sequencer neither reads nor writes
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !wr_valid && !fill);

   // R7: reads never run past the end of the cell buffer
   assert_cell_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fill |-> 32'(cell_idx) < PIX_PER_WORD * ROW_WORDS * ROWS);

   // R9: done is a single-cycle pulse that follows an accepted write
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && $past(wr_valid && wr_ready));

   // R10: a start pulse during a frame does not end or restart it
   assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !(accept && frame_end)) |=> busy && !load_frame);
endmodule

// File: rtl/heat_fb_packer.sv
module heat_fb_packer #(
   parameter int CELL_W     = 7,
   parameter int PIX_W      = 4,
   parameter int WORD_W     = 32,
   parameter int ROW_CELLS  = 320,
   parameter int ROWS       = 80,
   parameter int LINE_WORDS = 80,
   parameter int X_W        = 10,
   parameter int Y_W        = 9,
   parameter int FB_ADDR_W  = 16,
   localparam int PIX_PER_WORD = WORD_W / PIX_W,
   localparam int ROW_WORDS    = ROW_CELLS / PIX_PER_WORD,
   localparam int TOTAL_CELLS  = ROW_CELLS * ROWS,
   localparam int CELL_ADDR_W  = $clog2(TOTAL_CELLS),
   localparam int XSH          = $clog2(PIX_PER_WORD)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [X_W-1:0]         org_x,
   input  logic [Y_W-1:0]         org_y,
   output logic                   busy,
   output logic                   done,
   output logic                   cell_rd_en,
   output logic [CELL_ADDR_W-1:0] cell_rd_addr,
   input  logic [CELL_W-1:0]      cell_rd_data,
   output logic                   wr_valid,
   input  logic                   wr_ready,
   output logic [FB_ADDR_W-1:0]   wr_addr,
   output logic [WORD_W-1:0]      wr_data
);
   generate
      if (CELL_W < PIX_W) begin : g_bad_cell
         $error("CELL_W must be at least PIX_W");
      end
      if (WORD_W % PIX_W != 0 || PIX_PER_WORD < 2) begin : g_bad_word
         $error("WORD_W must hold two or more whole pixels");
      end
      if ((PIX_PER_WORD & (PIX_PER_WORD - 1)) != 0) begin : g_bad_pow
         $error("pixels per word must be a power of two");
      end
      if (ROW_CELLS % PIX_PER_WORD != 0) begin : g_bad_row
         $error("ROW_CELLS must be a whole number of words");
      end
      if (ROW_WORDS > LINE_WORDS) begin : g_bad_line
         $error("a row must fit in one screen line");
      end
   endgenerate

   logic load_frame;
   logic next_word;
   logic next_row;
   logic fill;

   hcp_seq #(
      .PIX_PER_WORD(PIX_PER_WORD),
      .ROW_WORDS   (ROW_WORDS),
      .ROWS        (ROWS),
      .CELL_ADDR_W (CELL_ADDR_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .wr_ready  (wr_ready),
      .busy      (busy),
      .done      (done),
      .fill      (fill),
      .wr_valid  (wr_valid),
      .load_frame(load_frame),
      .next_word (next_word),
      .next_row  (next_row),
      .cell_idx  (cell_rd_addr)
   );

   hcp_addr #(
      .FB_ADDR_W (FB_ADDR_W),
      .X_W       (X_W),
      .Y_W       (Y_W),
      .LINE_WORDS(LINE_WORDS),
      .ROW_WORDS (ROW_WORDS),
      .XSH       (XSH)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_frame(load_frame),
      .org_x     (org_x),
      .org_y     (org_y),
      .next_word (next_word),
      .next_row  (next_row),
      .wr_addr   (wr_addr)
   );

   hcp_pack #(
      .CELL_W(CELL_W),
      .PIX_W (PIX_W),
      .WORD_W(WORD_W)
   ) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (fill),
      .cell_data(cell_rd_data),
      .word     (wr_data)
   );

   assign cell_rd_en = fill;

   // R8: an offered word holds still under backpressure
   assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_data) && $stable(wr_addr));

   // R8: no cell reads while a word is offered
   assert_no_read_in_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> !cell_rd_en);
endmodule

// File: tb/sim_heat_fb_packer.sv
module sim_heat_fb_packer;
   localparam int ROWW  = 40;
   localparam int NROWS = 80;
   localparam int NWORD = ROWW * NROWS;
   localparam int NCELL = NWORD * 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [9:0]  org_x = '0;
   logic [8:0]  org_y = '0;
   logic        busy, done, cell_rd_en, wr_valid;
   logic        wr_ready = 1'b0;
   logic [14:0] cell_rd_addr;
   logic [6:0]  cell_rd_data;
   logic [15:0] wr_addr;
   logic [31:0] wr_data;

   int errors = 0;
   int checks = 0;
   int seed_cur = 1;
   int rdy_pct = 100;
   int exp_word = 0;
   int exp_read = 0;
   int base = 0;
   int read_err = 0;
   bit frame_on = 1'b0;
   bit frame_seen = 1'b0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   heat_fb_packer u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .org_x(org_x), .org_y(org_y),
      .busy(busy), .done(done), .cell_rd_en(cell_rd_en), .cell_rd_addr(cell_rd_addr),
      .cell_rd_data(cell_rd_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_addr(wr_addr), .wr_data(wr_data)
   );

   function automatic logic [6:0] cell_val(int idx, int sd);
      int h;
      h = (idx * 37 + sd * 11) ^ ((idx >> 3) * 5) ^ (sd << 2);
      return 7'(h);
   endfunction

   assign cell_rd_data = cell_val(int'(cell_rd_addr), seed_cur);

   // R2, R3: expected packing of word k
   function automatic logic [31:0] exp_data(int k, int sd);
      logic [31:0] w;
      logic [6:0]  c;
      w = '0;
      for (int j = 0; j < 8; j++) begin
         c = cell_val(k * 8 + j, sd);
         w = {w[27:0], c[6:3]};
      end
      return w;
   endfunction

   function automatic int exp_addr(int k, int b);
      return b + (k / ROWW) * 80 + (k % ROWW);
   endfunction

   task automatic check(bit ok, string req, longint got, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s got=%0h exp=%0h", req, got, exp);
      end
   endtask

   // monitor: drives ready, then checks what the next edge will do
   initial begin
      bit          prev_stall = 1'b0;
      logic [31:0] prev_data = '0;
      logic [15:0] prev_addr = '0;
      int          done_phase = 0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (done_phase == 1) begin
               check(done && !busy, "R9 done high, busy low", {done, busy}, 2'b10);
               check(exp_read == NCELL, "R7 cell reads per frame", exp_read, NCELL);
               check(read_err == 0, "R7 raster read order", read_err, 0);
               done_phase = 2;
               frame_on   = 1'b0;
               frame_seen = 1'b1;
            end else if (done_phase == 2) begin
               check(!done, "R9 done single cycle", done, 0);
               done_phase = 0;
            end else if (done) begin
               check(1'b0, "R9 unexpected done", done, 0);
            end
            wr_ready = ($urandom % 100) < rdy_pct;
            if (prev_stall) begin
               check(wr_valid && wr_data == prev_data && wr_addr == prev_addr,
                     "R8 hold under stall", {wr_valid, wr_addr, wr_data},
                     {1'b1, prev_addr, prev_data});
            end
            if (cell_rd_en) begin
               if (wr_valid) check(1'b0, "R8 read during offer", cell_rd_en, 0);
               if (int'(cell_rd_addr) != exp_read) read_err++;
               exp_read++;
            end
            if (wr_valid && wr_ready) begin
               if (!frame_on || exp_word >= NWORD) begin
                  check(1'b0, "R7 extra word", exp_word, NWORD);
               end else begin
                  logic [31:0] ed;
                  int          ea;
                  ed = exp_data(exp_word, seed_cur);
                  ea = exp_addr(exp_word, base);
                  check(wr_data == ed, "R2 R3 packed data", wr_data, ed);
                  if (exp_word == 0)
                     check(int'(wr_addr) == ea, "R4 first address", wr_addr, ea);
                  else if (exp_word % ROWW == 0)
                     check(int'(wr_addr) == ea, "R6 row start address", wr_addr, ea);
                  else
                     check(int'(wr_addr) == ea, "R5 in-row address", wr_addr, ea);
                  exp_word++;
                  if (exp_word == NWORD) done_phase = 1;
               end
            end
            prev_stall = wr_valid && !wr_ready;
            prev_data  = wr_data;
            prev_addr  = wr_addr;
         end
      end
   end

   task automatic run_frame(int x, int y, int sd, int pct);
      @(negedge clk);
      seed_cur   = sd;
      rdy_pct    = pct;
      exp_word   = 0;
      exp_read   = 0;
      read_err   = 0;
      base       = y * 80 + x / 8;
      frame_seen = 1'b0;
      frame_on   = 1'b1;
      org_x = 10'(x);
      org_y = 9'(y);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy, "R1 busy after start", busy, 1);
      repeat (150) @(negedge clk);
      // R10: second start with another origin, mid-frame
      org_x = 10'd512;
      org_y = 9'd77;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy, "R10 busy after ignored start", busy, 1);
      while (!frame_seen) @(negedge clk);
      check(exp_word == NWORD, "R7 words per frame", exp_word, NWORD);
      repeat (3) @(negedge clk);
      check(!busy && !wr_valid && !cell_rd_en, "R1 idle after frame",
            {busy, wr_valid, cell_rd_en}, 0);
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(!busy && !done && !wr_valid && !cell_rd_en, "R1 reset state",
            {busy, done, wr_valid, cell_rd_en}, 0);
      // R4: x=165 has low bits 101 which must be dropped
      run_frame(165, 3, 1, 100);
      // R4: x=7 rounds down to word 0
      run_frame(7, 0, 2, 70);
      // largest x, deep y, heavy backpressure
      run_frame(1023, 400, 3, 35);
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog got=timeout exp=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule